// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block works out which of a set of processor-local interrupt controllers should take a given interrupt. The request is either an inter-processor request or a message-signalled write. An inter-processor request brings its own destination byte, physical/logical mode bit, two-bit shorthand, delivery mode, vector and trigger bit. A message-signalled write brings an address and a data word, and the block takes those fields out of them. Each target provides a present flag, an 8-bit ID, the word last written to its logical-destination register and the word last written to its destination-format register.

Each request strobe produces one registered result one cycle later. The result holds a delivery bitmask with one bit per target, the lowest-indexed target in that mask, and the vector, delivery mode and trigger mode that were used. In lowest-priority delivery the mask is cut down to that single target. Injecting the interrupt and any arbitration between controllers are left to the logic that follows.

Top module: `irq_dest_resolver`

## Requirements
- R1: Shorthand code 1 (self) selects only the target whose index equals `req_index`, whatever the destination byte and mode bit are.
- R2: Shorthand code 2 selects every target. Shorthand code 3 selects every target except the one at `req_index`.
- R3: With shorthand 0 and the mode bit at 0 (physical), a destination of 0xFF selects every target. Any other destination selects each target whose ID equals it, and no target when none matches.
- R4: With shorthand 0 and the mode bit at 1 (logical), a target whose format nibble is 0xF (flat) matches when the destination byte ANDed with its logical ID is non-zero. The format nibble is bits [31:28] of its format word. The logical ID is bits [31:24] of its logical-destination word.
- R5: In logical mode, a target whose format nibble is 0x0 (cluster) matches when the upper nibble of the destination equals the upper nibble of its logical ID and the AND of the two lower nibbles is non-zero. A target with any other format nibble never matches in logical mode.
- R6: When the delivery mode is code 1 (lowest priority), the output mask holds only the lowest-indexed bit of the resolved mask.
- R7: When `req_msg` is 1, the block takes the destination from address bits [19:12], the mode bit from address bit 2, the vector from data bits [7:0], the delivery mode from data bits [10:8] and the trigger mode from data bit 15. The shorthand is treated as 0, and the inter-processor request fields are ignored.
- R8: A target whose `tgt_present` bit is 0 never appears in the output mask, even for a broadcast or a shorthand.
- R9: `out_valid` is high for exactly the cycle after each cycle in which `req_valid` is high. The result outputs change only in that cycle and hold their values otherwise.
- R10: `out_sel_valid` is 1 exactly when the output mask is non-zero. `out_sel_idx` is then the index of the lowest set bit of the output mask.
- R11: While reset is asserted, `out_valid`, `out_mask`, `out_sel_valid` and `out_sel_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request strobe |
| req_msg | input | 1 | 1: decode fields from `msg_addr`/`msg_data`; 0: use the inter-processor fields |
| req_dest | input | 8 | Destination byte (inter-processor) |
| req_logical | input | 1 | 0 physical, 1 logical (inter-processor) |
| req_shorthand | input | 2 | 0 field, 1 self, 2 all, 3 all but self |
| req_dmode | input | 3 | Delivery mode; code 1 is lowest priority |
| req_vector | input | 8 | Vector (inter-processor) |
| req_trig | input | 1 | Trigger mode (inter-processor) |
| msg_addr | input | 32 | Message-signalled address word |
| msg_data | input | 32 | Message-signalled data word |
| req_index | input | IDX_W | Index of the requesting target |
| tgt_present | input | NUM_TGT | Per-target present flag |
| tgt_id | input | 8*NUM_TGT | Per-target physical ID, target k at bits [8k+7:8k] |
| tgt_ldr_word | input | 32*NUM_TGT | Per-target logical-destination register word |
| tgt_fmt_word | input | 32*NUM_TGT | Per-target destination-format register word |
| out_valid | output | 1 | Result valid pulse |
| out_mask | output | NUM_TGT | Delivery bitmask |
| out_sel_valid | output | 1 | Mask is non-zero |
| out_sel_idx | output | IDX_W | Lowest-indexed selected target |
| out_vector | output | 8 | Vector used |
| out_dmode | output | 3 | Delivery mode used |
| out_trig | output | 1 | Trigger mode used |

## Verification
The cluster rule is the hardest case to reach from the ports. A hit needs the upper nibbles to be equal and the lower nibbles to overlap at the same time, and in the same sweep flat targets, targets with other format codes and absent targets must still stay out. The bench fixes one mixed population of flat, cluster, foreign-format and absent targets and sends all 256 destination bytes in logical mode, once in fixed delivery and once in lowest-priority delivery. It also sends all 256 destinations in physical mode against a set of IDs that includes a duplicate. The shorthands are swept over every requester index and several present patterns. Message-signalled requests carry stray bits and inter-processor fields that conflict with them.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

  localparam int DEST_W = 8;
  localparam int WORD_W = 32;
  localparam int VEC_W  = 8;
  localparam int DM_W   = 3;

  // field positions inside the message-signalled address/data words
  localparam int MSG_DEST_LSB  = 12;
  localparam int MSG_MODE_BIT  = 2;
  localparam int MSG_DMODE_LSB = 8;
  localparam int MSG_TRIG_BIT  = 15;
  localparam int MSG_VEC_LSB   = 0;

  // field positions inside the per-target register words
  localparam int LDR_LSB = 24;
  localparam int FMT_LSB = 28;

  localparam logic [3:0]        FMT_FLAT    = 4'hF;
  localparam logic [3:0]        FMT_CLUSTER = 4'h0;
  localparam logic [DEST_W-1:0] PHYS_BCAST  = 8'hFF;
  localparam logic [DM_W-1:0]   DM_LOWEST   = 3'd1;

  typedef enum logic [1:0] {
    SH_FIELD  = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              logical;
    shorthand_e        sh;
    logic [DM_W-1:0]   dmode;
    logic [VEC_W-1:0]  vector;
    logic              trig;
  } req_t;

endpackage

// File: rtl/irq_req_decode.sv
module irq_req_decode
  import irq_dest_pkg::*;
(
  input  logic                use_msg,
  input  logic [DEST_W-1:0]   ipi_dest,
  input  logic                ipi_logical,
  input  logic [1:0]          ipi_shorthand,
  input  logic [DM_W-1:0]     ipi_dmode,
  input  logic [VEC_W-1:0]    ipi_vector,
  input  logic                ipi_trig,
  input  logic [WORD_W-1:0]   msg_addr,
  input  logic [WORD_W-1:0]   msg_data,
  output req_t                req
);

  logic unused_msg_bits;
  assign unused_msg_bits = ^{msg_addr[31:20], msg_addr[11:3], msg_addr[1:0],
                             msg_data[31:16], msg_data[14:11]};

  always_comb begin
    if (use_msg) begin
      req.dest    = msg_addr[MSG_DEST_LSB +: DEST_W];
      req.logical = msg_addr[MSG_MODE_BIT];
      req.sh      = SH_FIELD;
      req.dmode   = msg_data[MSG_DMODE_LSB +: DM_W];
      req.vector  = msg_data[MSG_VEC_LSB +: VEC_W];
      req.trig    = msg_data[MSG_TRIG_BIT];
    end else begin
      req.dest    = ipi_dest;
      req.logical = ipi_logical;
      req.sh      = shorthand_e'(ipi_shorthand);
      req.dmode   = ipi_dmode;
      req.vector  = ipi_vector;
      req.trig    = ipi_trig;
    end
  end

endmodule

// File: rtl/irq_tgt_match.sv
module irq_tgt_match
  import irq_dest_pkg::*;
(
  input  logic              present,
  input  logic              is_requester,
  input  logic [DEST_W-1:0] dest,
  input  logic              logical,
  input  shorthand_e        sh,
  input  logic [DEST_W-1:0] id,
  input  logic [WORD_W-1:0] ldr_word,
  input  logic [WORD_W-1:0] fmt_word,
  output logic              hit
);

  logic [DEST_W-1:0] ldr;
  logic [3:0]        fmt;
  logic              phys_hit;
  logic              flat_hit;
  logic              clus_hit;
  logic              field_hit;
  logic              unused_word_bits;

  assign ldr = ldr_word[LDR_LSB +: DEST_W];
  assign fmt = fmt_word[FMT_LSB +: 4];
  assign unused_word_bits = ^{ldr_word[LDR_LSB-1:0], fmt_word[FMT_LSB-1:0]};

  always_comb begin
    phys_hit = (dest == PHYS_BCAST) || (dest == id);
    flat_hit = (fmt == FMT_FLAT) && ((dest & ldr) != '0);
    clus_hit = (fmt == FMT_CLUSTER) && (dest[7:4] == ldr[7:4]) &&
               ((dest[3:0] & ldr[3:0]) != 4'h0);
    field_hit = logical ? (flat_hit || clus_hit) : phys_hit;
  end

  always_comb begin
    unique case (sh)
      SH_FIELD:  hit = present && field_hit;
      SH_SELF:   hit = present && is_requester;
      SH_ALL:    hit = present;
      SH_OTHERS: hit = present && !is_requester;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int NUM_TGT = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_TGT-1:0] mask,
  output logic               found,
  output logic [IDX_W-1:0]   idx,
  output logic [NUM_TGT-1:0] onehot
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_TGT - 1; i >= 0; i--) begin
      if (mask[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
    onehot = found ? (NUM_TGT'(1) << idx) : '0;
  end

endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_dest_pkg::*;
#(
  parameter int NUM_TGT = 8,
  parameter int IDX_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_msg,
  input  logic [7:0]                req_dest,
  input  logic                      req_logical,
  input  logic [1:0]                req_shorthand,
  input  logic [2:0]                req_dmode,
  input  logic [7:0]                req_vector,
  input  logic                      req_trig,
  input  logic [31:0]               msg_addr,
  input  logic [31:0]               msg_data,
  input  logic [IDX_W-1:0]          req_index,
  input  logic [NUM_TGT-1:0]        tgt_present,
  input  logic [8*NUM_TGT-1:0]      tgt_id,
  input  logic [32*NUM_TGT-1:0]     tgt_ldr_word,
  input  logic [32*NUM_TGT-1:0]     tgt_fmt_word,
  output logic                      out_valid,
  output logic [NUM_TGT-1:0]        out_mask,
  output logic                      out_sel_valid,
  output logic [IDX_W-1:0]          out_sel_idx,
  output logic [7:0]                out_vector,
  output logic [2:0]                out_dmode,
  output logic                      out_trig
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // request decode
  req_t req;

  irq_req_decode u_dec (
    .use_msg       (req_msg),
    .ipi_dest      (req_dest),
    .ipi_logical   (req_logical),
    .ipi_shorthand (req_shorthand),
    .ipi_dmode     (req_dmode),
    .ipi_vector    (req_vector),
    .ipi_trig      (req_trig),
    .msg_addr      (msg_addr),
    .msg_data      (msg_data),
    .req           (req)
  );

  // per-target match
  logic [NUM_TGT-1:0] raw_mask;

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
    irq_tgt_match u_match (
      .present      (tgt_present[g]),
      .is_requester (req_index == IDX_W'(g)),
      .dest         (req.dest),
      .logical      (req.logical),
      .sh           (req.sh),
      .id           (tgt_id[g*DEST_W +: DEST_W]),
      .ldr_word     (tgt_ldr_word[g*WORD_W +: WORD_W]),
      .fmt_word     (tgt_fmt_word[g*WORD_W +: WORD_W]),
      .hit          (raw_mask[g])
    );
  end

  // lowest-indexed pick
  logic               pick_found;
  logic [IDX_W-1:0]   pick_idx;
  logic [NUM_TGT-1:0] pick_onehot;

  irq_lowest_pick #(.NUM_TGT(NUM_TGT), .IDX_W(IDX_W)) u_pick (
    .mask   (raw_mask),
    .found  (pick_found),
    .idx    (pick_idx),
    .onehot (pick_onehot)
  );

  // next state
  logic [NUM_TGT-1:0] nxt_mask;

  always_comb begin
    nxt_mask = (req.dmode == DM_LOWEST) ? pick_onehot : raw_mask;
  end

  // result registers
  logic               valid_q;
  logic [NUM_TGT-1:0] mask_q;
  logic               sel_valid_q;
  logic [IDX_W-1:0]   sel_idx_q;
  logic [VEC_W-1:0]   vector_q;
  logic [DM_W-1:0]    dmode_q;
  logic               trig_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q     <= 1'b0;
      mask_q      <= '0;
      sel_valid_q <= 1'b0;
      sel_idx_q   <= '0;
      vector_q    <= '0;
      dmode_q     <= '0;
      trig_q      <= 1'b0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        mask_q      <= nxt_mask;
        sel_valid_q <= pick_found;
        sel_idx_q   <= pick_idx;
        vector_q    <= req.vector;
        dmode_q     <= req.dmode;
        trig_q      <= req.trig;
      end
    end
  end

  assign out_valid     = valid_q;
  assign out_mask      = mask_q;
  assign out_sel_valid = sel_valid_q;
  assign out_sel_idx   = sel_idx_q;
  assign out_vector    = vector_q;
  assign out_dmode     = dmode_q;
  assign out_trig      = trig_q;

endmodule

// File: rtl/irq_dest_resolver_chk.sv
module irq_dest_resolver_chk #(
  parameter int NUM_TGT = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rst_int_n,
  input logic               req_valid,
  input logic               req_msg,
  input logic [1:0]         req_shorthand,
  input logic [IDX_W-1:0]   req_index,
  input logic [NUM_TGT-1:0] tgt_present,
  input logic               out_valid,
  input logic [NUM_TGT-1:0] out_mask,
  input logic               out_sel_valid,
  input logic [IDX_W-1:0]   out_sel_idx,
  input logic [2:0]         out_dmode
);

  // R9: one result pulse per strobe
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid |=> out_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_valid |=> !out_valid);
  // R9: result holds between strobes
  a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_valid |=> $stable(out_mask));

  // R8: absent targets never delivered
  a_r8_absent_clear: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> ((out_mask & ~$past(tgt_present)) == '0));

  // R6: lowest priority yields at most one target
  a_r6_lowest_single: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && out_dmode == 3'd1) |-> $onehot0(out_mask));

  // R10: selection agrees with mask
  a_r10_sel_flag: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> (out_sel_valid == (out_mask != '0)));
  a_r10_sel_lowest: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && out_sel_valid) |->
      (((out_mask >> out_sel_idx) & NUM_TGT'(1)) != '0) &&
      ((out_mask & ((NUM_TGT'(1) << out_sel_idx) - NUM_TGT'(1))) == '0));

  // R1: self shorthand
  a_r1_self_only: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && $past(!req_msg && req_shorthand == 2'd1)) |->
      (out_mask == ($past(tgt_present) & (NUM_TGT'(1) << $past(req_index)))));

  // R2: all-but-self never includes the requester
  a_r2_others_excl: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && $past(!req_msg && req_shorthand == 2'd3)) |->
      (((out_mask >> $past(req_index)) & NUM_TGT'(1)) == '0));

  // R11: quiet while the external reset is low
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r11_reset_quiet: assert (!out_valid && out_mask == '0 && !out_sel_valid);
    end
  end

endmodule

bind irq_dest_resolver irq_dest_resolver_chk #(.NUM_TGT(NUM_TGT), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_irq_dest_resolver.sv
module sim_irq_dest_resolver;

  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_msg;
  logic [7:0]    req_dest;
  logic          req_logical;
  logic [1:0]    req_shorthand;
  logic [2:0]    req_dmode;
  logic [7:0]    req_vector;
  logic          req_trig;
  logic [31:0]   msg_addr;
  logic [31:0]   msg_data;
  logic [IW-1:0] req_index;
  logic [N-1:0]  tgt_present;
  logic [8*N-1:0]  tgt_id;
  logic [32*N-1:0] tgt_ldr_word;
  logic [32*N-1:0] tgt_fmt_word;
  logic          out_valid;
  logic [N-1:0]  out_mask;
  logic          out_sel_valid;
  logic [IW-1:0] out_sel_idx;
  logic [7:0]    out_vector;
  logic [2:0]    out_dmode;
  logic          out_trig;

  logic [7:0]  b_id [N];
  logic [7:0]  b_ld [N];
  logic [3:0]  b_fm [N];

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int t = 0; t < N; t++) begin
      tgt_id[t*8 +: 8]         = b_id[t];
      tgt_ldr_word[t*32 +: 32] = {b_ld[t], 24'h5A3C96};
      tgt_fmt_word[t*32 +: 32] = {b_fm[t], 28'h0F0F0F3};
    end
  end

  irq_dest_resolver #(.NUM_TGT(N)) u0 (
    .clk, .rst_n, .req_valid, .req_msg, .req_dest, .req_logical,
    .req_shorthand, .req_dmode, .req_vector, .req_trig, .msg_addr,
    .msg_data, .req_index, .tgt_present, .tgt_id, .tgt_ldr_word,
    .tgt_fmt_word, .out_valid, .out_mask, .out_sel_valid, .out_sel_idx,
    .out_vector, .out_dmode, .out_trig
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // expected mask computed from the requirements
  function automatic logic [N-1:0] model(input logic [7:0] d, input logic lg,
                                          input logic [1:0] sh, input int idx,
                                          input logic [2:0] dm);
    logic [N-1:0] m;
    logic [N-1:0] low;
    for (int t = 0; t < N; t++) begin
      logic h;
      case (sh)
        2'd1: h = (t == idx);
        2'd2: h = 1'b1;
        2'd3: h = (t != idx);
        default: begin
          if (!lg) h = (d == 8'hFF) || (d == b_id[t]);
          else if (b_fm[t] == 4'hF) h = (d & b_ld[t]) != 8'h00;
          else if (b_fm[t] == 4'h0)
            h = (d[7:4] == b_ld[t][7:4]) && ((d[3:0] & b_ld[t][3:0]) != 4'h0);
          else h = 1'b0;
        end
      endcase
      m[t] = h && tgt_present[t];
    end
    low = m & (~m + 1'b1);
    return (dm == 3'd1) ? low : m;
  endfunction

  function automatic int lowest(input logic [N-1:0] m);
    for (int t = 0; t < N; t++) if (m[t]) return t;
    return 0;
  endfunction

  logic [N-1:0] last_exp;

  task automatic do_req(input string rq, input logic msg, input logic [7:0] d,
                        input logic lg, input logic [1:0] sh, input logic [2:0] dm,
                        input int idx, input logic [31:0] ma, input logic [31:0] md);
    logic [7:0] ed; logic el; logic [1:0] es; logic [2:0] edm;
    logic [7:0] ev; logic et; logic [N-1:0] em;
    @(negedge clk);
    req_msg = msg; req_dest = d; req_logical = lg; req_shorthand = sh;
    req_dmode = dm; req_vector = 8'h3C; req_trig = 1'b1;
    req_index = IW'(idx); msg_addr = ma; msg_data = md;
    req_valid = 1'b1;
    if (msg) begin
      ed = ma[19:12]; el = ma[2]; es = 2'd0; edm = md[10:8]; ev = md[7:0]; et = md[15];
    end else begin
      ed = d; el = lg; es = sh; edm = dm; ev = 8'h3C; et = 1'b1;
    end
    em = model(ed, el, es, idx, edm);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 valid", 32'(out_valid), 32'd1);
    chk(rq, 32'(out_mask), 32'(em));
    chk("R10 sel_valid", 32'(out_sel_valid), 32'(em != '0));
    if (em != '0) chk("R10 sel_idx", 32'(out_sel_idx), 32'(lowest(em)));
    if (msg) begin
      chk("R7 vector", 32'(out_vector), 32'(ev));
      chk("R7 dmode", 32'(out_dmode), 32'(edm));
      chk("R7 trig", 32'(out_trig), 32'(et));
    end
    last_exp = em;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_msg = 1'b0; req_dest = '0;
    req_logical = 1'b0; req_shorthand = '0; req_dmode = '0; req_vector = '0;
    req_trig = 1'b0; msg_addr = '0; msg_data = '0; req_index = '0;
    tgt_present = '1;
    for (int t = 0; t < N; t++) begin b_id[t] = 8'(t); b_ld[t] = '0; b_fm[t] = 4'hF; end
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 valid", 32'(out_valid), 0);
    chk("R11 mask", 32'(out_mask), 0);
    chk("R11 sel_valid", 32'(out_sel_valid), 0);
    chk("R11 sel_idx", 32'(out_sel_idx), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1, R2, R8: shorthands over every requester and several present patterns
    for (int p = 0; p < 3; p++) begin
      tgt_present = (p == 0) ? 8'hFF : (p == 1) ? 8'hA5 : 8'h5A;
      for (int sh = 1; sh < 4; sh++)
        for (int i = 0; i < N; i++)
          for (int dm = 0; dm < 2; dm++)
            do_req((sh == 1) ? "R1 self" : "R2 all/others R8", 1'b0, 8'hFF,
                   1'(i & 1), 2'(sh), 3'(dm), i, '0, '0);
    end

    // R3, R8: physical sweep of all destinations, duplicate ID at 1 and 3
    b_id[0] = 8'h00; b_id[1] = 8'h05; b_id[2] = 8'h10; b_id[3] = 8'h05;
    b_id[4] = 8'h7E; b_id[5] = 8'hFE; b_id[6] = 8'h21; b_id[7] = 8'h33;
    tgt_present = 8'hEF;
    for (int d = 0; d < 256; d++)
      do_req("R3 physical", 1'b0, 8'(d), 1'b0, 2'd0, 3'd0, d % N, '0, '0);

    // R4, R5, R6: logical sweep over a mixed flat/cluster/other population
    b_fm[0] = 4'hF; b_ld[0] = 8'h01;
    b_fm[1] = 4'hF; b_ld[1] = 8'h82;
    b_fm[2] = 4'hF; b_ld[2] = 8'h00;
    b_fm[3] = 4'h0; b_ld[3] = 8'h31;
    b_fm[4] = 4'h0; b_ld[4] = 8'h32;
    b_fm[5] = 4'h0; b_ld[5] = 8'h5C;
    b_fm[6] = 4'h7; b_ld[6] = 8'hFF;
    b_fm[7] = 4'hF; b_ld[7] = 8'h40;
    tgt_present = 8'h7F;
    for (int dm = 0; dm < 2; dm++)
      for (int d = 0; d < 256; d++)
        do_req((dm == 1) ? "R6 lowest R4/R5" : "R4 flat / R5 cluster",
               1'b0, 8'(d), 1'b1, 2'd0, 3'(dm), 0, '0, '0);

    // R7: message-signalled decode, stray bits and conflicting direct fields
    tgt_present = 8'hFF;
    do_req("R7 msg phys", 1'b1, 8'h31, 1'b1, 2'd1, 3'd0, 2,
           32'hFEE0_5_0_0_8 | 32'h0000_0FF0 & 32'h0 | 32'h0005_0000 & 32'h0 | 32'h0002_1000, 32'hABCD_0041);
    do_req("R7 msg bcast", 1'b1, 8'h00, 1'b0, 2'd3, 3'd1, 4,
           32'hFEEF_F003, 32'h1234_8262);
    do_req("R7 msg logical", 1'b1, 8'h00, 1'b0, 2'd2, 3'd0, 0,
           32'hFEE3_3FFC, 32'hFFFF_71A7);
    do_req("R7 msg lowest", 1'b1, 8'h00, 1'b0, 2'd1, 3'd0, 5,
           32'hFEE8_3004, 32'h0000_0155);
    do_req("R7 msg none", 1'b1, 8'hFF, 1'b0, 2'd2, 3'd0, 1,
           32'h00099000, 32'h0000_8000);

    // R9: outputs hold when no strobe
    do_req("R9 setup", 1'b0, 8'h82, 1'b1, 2'd0, 3'd0, 0, '0, '0);
    @(negedge clk);
    req_dest = 8'h01; req_shorthand = 2'd2; tgt_present = 8'h0F;
    @(negedge clk);
    chk("R9 no valid", 32'(out_valid), 0);
    chk("R9 hold mask", 32'(out_mask), 32'(last_exp));

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule